// File: doc/BRIEF.md
# Single-Position Shift and Rotate Unit

This block moves the bits of an operand by exactly one position and produces the condition flags that go with the move. One datapath serves three operand sizes: 8, 16 and 32 bits. The size select chooses which bit counts as the most significant bit, and which bit feeds the sign, zero, overflow and carry flags. In the narrower sizes the bits above the selected width leave the block unchanged.

Eight operations are available: arithmetic and logical shifts in each direction, plain rotates in each direction, and rotates through the carry flag in each direction. A rotate through carry puts the incoming carry into the bit that the move leaves empty. On every operation, the bit pushed out of the selected width becomes the new carry. The inputs are sampled on each rising clock edge, and the result and flags are registered. They are valid one cycle later.

Top module: `shrot_unit`

## Requirements
- R1: The result and all four flags are registered. Inputs sampled on a rising edge appear at the outputs after that edge. While `rst_n` is low, the outputs are all zero.
- R2: `size_sel` 0 selects 8 bits, 1 selects 16 bits and 2 selects 32 bits. In 8-bit and 16-bit mode, result bits above the selected width equal the operand bits.
- R3: `op_sel` 0 (arithmetic left) and 1 (logical left) shift toward the MSB, put 0 into bit 0, and copy the old MSB of the selected size into C.
- R4: `op_sel` 3 (logical right) shifts toward bit 0, puts 0 into the selected MSB, and copies old bit 0 into C.
- R5: `op_sel` 2 (arithmetic right) shifts toward bit 0, leaves the selected MSB at its old value, and copies old bit 0 into C.
- R6: `op_sel` 4 (rotate left) moves the old selected MSB into bit 0 and into C.
- R7: `op_sel` 5 (rotate right) moves old bit 0 into the selected MSB and into C.
- R8: `op_sel` 6 (rotate left through carry) puts `carry_in` into bit 0 and the old MSB into C. `op_sel` 7 (rotate right through carry) puts `carry_in` into the selected MSB and old bit 0 into C.
- R9: N equals the result bit at the selected MSB. Z is 1 exactly when the selected-width part of the result is all zero, whatever the upper bits hold.
- R10: V is 1 after an arithmetic left shift whose result MSB differs from the operand MSB. V is 0 after every other operation.
- R11: `size_sel` 3 behaves exactly like 32-bit mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| operand | input | 32 | Value to shift or rotate |
| size_sel | input | 2 | Operand width: 0 = 8, 1 = 16, 2 or 3 = 32 |
| op_sel | input | 3 | Operation code (see R3 to R8) |
| carry_in | input | 1 | Incoming carry flag |
| result | output | 32 | Registered result |
| flag_n | output | 1 | Sign of the selected-width result |
| flag_z | output | 1 | Selected-width result is zero |
| flag_v | output | 1 | Sign change on an arithmetic left shift |
| flag_c | output | 1 | Bit shifted out |

## Verification
The block holds only one output register, so a wrong internal value shows at the ports in the cycle right after the inputs that caused it. Nothing lingers from one operation to the next. The most likely faults are size dependent: a tap taken from the wrong lane, or an upper pass-through that is lost. Such a fault only shows for particular sizes, so every operation is run at every size, including size code 3. The operand patterns are chosen so that the MSB, bit 0, the upper bits and the incoming carry each differ. With those patterns, a fill or carry taken from the wrong source always flips a visible bit.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    typedef enum logic [2:0] {
        OP_ASL = 3'd0,
        OP_LSL = 3'd1,
        OP_ASR = 3'd2,
        OP_LSR = 3'd3,
        OP_ROL = 3'd4,
        OP_ROR = 3'd5,
        OP_RCL = 3'd6,
        OP_RCR = 3'd7
    } shrot_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } shrot_flags_t;

    function automatic logic op_is_left(input shrot_op_e op);
        return (op == OP_ASL) || (op == OP_LSL) || (op == OP_ROL) || (op == OP_RCL);
    endfunction

endpackage

// File: rtl/shrot_shift_path.sv
module shrot_shift_path
    import shrot_pkg::*;
#(
    parameter int BASE_W    = 8,
    parameter int NUM_LANES = 3,
    localparam int DATA_W   = BASE_W << (NUM_LANES - 1),
    localparam int SEL_W    = $clog2(NUM_LANES)
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [SEL_W-1:0]  lane_idx,
    input  shrot_op_e         op,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              carry_out,
    output logic              old_msb,
    output logic              old_nmsb
);

    logic [DATA_W-1:0] lane_res [NUM_LANES];
    logic [NUM_LANES-1:0] lane_msb;
    logic [NUM_LANES-1:0] lane_nmsb;
    logic go_left;
    logic fill_lo;
    logic fill_hi;

    assign go_left = op_is_left(op);

    generate
        for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
            localparam int W = BASE_W << g;
            assign lane_msb[g]  = operand[W-1];
            assign lane_nmsb[g] = operand[W-2];
            if (W == DATA_W) begin : g_full
                assign lane_res[g] = go_left ? {operand[W-2:0], fill_lo}
                                             : {fill_hi, operand[W-1:1]};
            end else begin : g_part
                assign lane_res[g] = go_left ? {operand[DATA_W-1:W], operand[W-2:0], fill_lo}
                                             : {operand[DATA_W-1:W], fill_hi, operand[W-1:1]};
            end
        end
    endgenerate

    assign old_msb  = lane_msb[lane_idx];
    assign old_nmsb = lane_nmsb[lane_idx];

    always_comb begin
        fill_lo = 1'b0;
        fill_hi = 1'b0;
        case (op)
            OP_ROL:  fill_lo = old_msb;
            OP_RCL:  fill_lo = carry_in;
            OP_ASR:  fill_hi = old_msb;
            OP_ROR:  fill_hi = operand[0];
            OP_RCR:  fill_hi = carry_in;
            default: begin
                fill_lo = 1'b0;
                fill_hi = 1'b0;
            end
        endcase
    end

    assign carry_out = go_left ? old_msb : operand[0];
    assign result    = lane_res[lane_idx];

endmodule

// File: rtl/shrot_flag_gen.sv
module shrot_flag_gen
    import shrot_pkg::*;
#(
    parameter int BASE_W    = 8,
    parameter int NUM_LANES = 3,
    localparam int DATA_W   = BASE_W << (NUM_LANES - 1),
    localparam int SEL_W    = $clog2(NUM_LANES)
) (
    input  logic [DATA_W-1:0] result,
    input  logic [SEL_W-1:0]  lane_idx,
    input  shrot_op_e         op,
    input  logic              old_msb,
    input  logic              old_nmsb,
    input  logic              carry_out,
    output shrot_flags_t      flags
);

    logic [NUM_LANES-1:0] res_msb;
    logic [NUM_LANES-1:0] res_zero;

    generate
        for (genvar g = 0; g < NUM_LANES; g++) begin : g_tap
            localparam int W = BASE_W << g;
            assign res_msb[g]  = result[W-1];
            assign res_zero[g] = ~|result[W-1:0];
        end
    endgenerate

    always_comb begin
        flags.n = res_msb[lane_idx];
        flags.z = res_zero[lane_idx];
        flags.v = (op == OP_ASL) && (old_msb != old_nmsb);
        flags.c = carry_out;
    end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int BASE_W    = 8,
    parameter int NUM_LANES = 3,
    localparam int DATA_W   = BASE_W << (NUM_LANES - 1),
    localparam int SEL_W    = $clog2(NUM_LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] operand,
    input  logic [SEL_W-1:0]  size_sel,
    input  logic [2:0]        op_sel,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c
);

    typedef struct packed {
        logic [DATA_W-1:0] res;
        shrot_flags_t      flg;
    } out_t;

    out_t              out_d, out_q;
    logic              seen_d, seen_q;
    logic [SEL_W-1:0]  lane_idx;
    shrot_op_e         op;
    logic [DATA_W-1:0] path_res;
    logic              path_c;
    logic              tap_msb;
    logic              tap_nmsb;
    shrot_flags_t      path_flags;

    assign op = shrot_op_e'(op_sel);

    always_comb begin
        if (int'(size_sel) >= NUM_LANES) lane_idx = SEL_W'(NUM_LANES - 1);
        else                             lane_idx = size_sel;
    end

    shrot_shift_path #(.BASE_W(BASE_W), .NUM_LANES(NUM_LANES)) path_i (
        .operand   (operand),
        .lane_idx  (lane_idx),
        .op        (op),
        .carry_in  (carry_in),
        .result    (path_res),
        .carry_out (path_c),
        .old_msb   (tap_msb),
        .old_nmsb  (tap_nmsb)
    );

    shrot_flag_gen #(.BASE_W(BASE_W), .NUM_LANES(NUM_LANES)) flags_i (
        .result    (path_res),
        .lane_idx  (lane_idx),
        .op        (op),
        .old_msb   (tap_msb),
        .old_nmsb  (tap_nmsb),
        .carry_out (path_c),
        .flags     (path_flags)
    );

    always_comb begin
        out_d.res = path_res;
        out_d.flg = path_flags;
        seen_d    = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            out_q  <= out_d;
            seen_q <= seen_d;
        end
    end

    assign result = out_q.res;
    assign flag_n = out_q.flg.n;
    assign flag_z = out_q.flg.z;
    assign flag_v = out_q.flg.v;
    assign flag_c = out_q.flg.c;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && !flag_n && !flag_z && !flag_v && !flag_c));

    assert_upper_hold_R2: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        ($past(size_sel) == '0) |-> (result[DATA_W-1:BASE_W] == $past(operand[DATA_W-1:BASE_W])));

    assert_left_fill_R3: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        ($past(op) == OP_ASL || $past(op) == OP_LSL) |-> (!result[0] && flag_c == $past(tap_msb)));

    assert_asr_sign_R5: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        ($past(op) == OP_ASR) |-> (flag_n == $past(tap_msb)));

    assert_rol_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        ($past(op) == OP_ROL) |-> (result[0] == flag_c));

    assert_ror_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        ($past(op) == OP_ROR) |-> (flag_n == flag_c));

    assert_v_clear_R10: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        ($past(op) != OP_ASL) |-> !flag_v);

endmodule

// File: tb/shrot_unit_tb_top.sv
module shrot_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] operand = '0;
    logic [1:0]  size_sel = '0;
    logic [2:0]  op_sel = '0;
    logic        carry_in = 1'b0;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_v, flag_c;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    shrot_unit dut_i (
        .clk(clk), .rst_n(rst_n), .operand(operand), .size_sel(size_sel),
        .op_sel(op_sel), .carry_in(carry_in), .result(result),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    // Reference built from the requirements: {result, n, z, v, c}
    function automatic logic [35:0] model(input logic [2:0] op, input logic [1:0] sz,
                                          input logic [31:0] d, input logic cin);
        int w;
        logic left, fill, msb, lsb, n, z, v, c;
        logic [31:0] r;
        w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        msb = d[w-1];
        lsb = d[0];
        left = (op == 3'd0) || (op == 3'd1) || (op == 3'd4) || (op == 3'd6);
        case (op)
            3'd2: fill = msb;
            3'd4: fill = msb;
            3'd5: fill = lsb;
            3'd6: fill = cin;
            3'd7: fill = cin;
            default: fill = 1'b0;
        endcase
        for (int i = 0; i < 32; i++) begin
            if (i >= w)      r[i] = d[i];
            else if (left)   r[i] = (i == 0) ? fill : d[i-1];
            else             r[i] = (i == w - 1) ? fill : d[i+1];
        end
        c = left ? msb : lsb;
        n = r[w-1];
        z = 1'b1;
        for (int i = 0; i < w; i++) if (r[i]) z = 1'b0;
        v = (op == 3'd0) && (r[w-1] != msb);
        return {r, n, z, v, c};
    endfunction

    task automatic check(input string tag, input logic [35:0] got, input logic [35:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got res=%h nzvc=%b expected res=%h nzvc=%b",
                     tag, got[35:4], got[3:0], exp[35:4], exp[3:0]);
        end
    endtask

    task automatic apply(input string tag, input logic [2:0] op, input logic [1:0] sz,
                         input logic [31:0] d, input logic cin);
        @(negedge clk);
        op_sel = op; size_sel = sz; operand = d; carry_in = cin;
        @(negedge clk);
        check(tag, {result, flag_n, flag_z, flag_v, flag_c}, model(op, sz, d, cin));
    endtask

    task automatic expect_fixed(input string tag, input logic [35:0] exp);
        check(tag, {result, flag_n, flag_z, flag_v, flag_c}, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        operand = 32'hFFFF_FFFF; op_sel = 3'd4; carry_in = 1'b1;
        @(negedge clk);
        expect_fixed("R1 reset outputs zero", 36'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_latency;
        logic [35:0] held;
        apply("R1 one-cycle result", 3'd1, 2'd2, 32'h1234_5678, 1'b0);
        held = {result, flag_n, flag_z, flag_v, flag_c};
        op_sel = 3'd3; operand = 32'h0000_0001;
        #1;
        expect_fixed("R1 output holds before edge", held);
        @(negedge clk);
        expect_fixed("R1 new value after edge", model(3'd3, 2'd2, 32'h0000_0001, 1'b0));
    endtask

    task automatic t_left;
        apply("R3 asl byte", 3'd0, 2'd0, 32'h0000_0040, 1'b1);
        expect_fixed("R3 asl byte value", {32'h0000_0080, 4'b1010});
        apply("R3 lsl word", 3'd1, 2'd1, 32'h0000_8001, 1'b1);
        expect_fixed("R3 lsl word value", {32'h0000_0002, 4'b0001});
    endtask

    task automatic t_right;
        apply("R4 lsr long", 3'd3, 2'd2, 32'h8000_0001, 1'b1);
        expect_fixed("R4 lsr long value", {32'h4000_0000, 4'b0001});
        apply("R5 asr byte", 3'd2, 2'd0, 32'h0000_0081, 1'b0);
        expect_fixed("R5 asr byte value", {32'h0000_00C0, 4'b1001});
        apply("R5 asr word", 3'd2, 2'd1, 32'h0000_7FFE, 1'b0);
    endtask

    task automatic t_rotate;
        apply("R6 rol word", 3'd4, 2'd1, 32'h0000_8000, 1'b0);
        expect_fixed("R6 rol word value", {32'h0000_0001, 4'b0001});
        apply("R7 ror byte", 3'd5, 2'd0, 32'h0000_0001, 1'b0);
        expect_fixed("R7 ror byte value", {32'h0000_0080, 4'b1001});
    endtask

    task automatic t_carry_rotate;
        apply("R8 rcl long", 3'd6, 2'd2, 32'h0000_0000, 1'b1);
        expect_fixed("R8 rcl long value", {32'h0000_0001, 4'b0000});
        apply("R8 rcr byte", 3'd7, 2'd0, 32'h0000_0002, 1'b1);
        expect_fixed("R8 rcr byte value", {32'h0000_0081, 4'b1000});
        apply("R8 rcr word cin0", 3'd7, 2'd1, 32'h0000_8001, 1'b0);
    endtask

    task automatic t_sizes;
        apply("R2 upper kept byte", 3'd5, 2'd0, 32'hDEAD_BE41, 1'b0);
        expect_fixed("R2 upper kept byte value", {32'hDEAD_BEA0, 4'b1001});
        apply("R2 upper kept word", 3'd1, 2'd1, 32'hCAFE_8001, 1'b0);
        apply("R11 size 3 is long", 3'd4, 2'd3, 32'h8000_0000, 1'b0);
        expect_fixed("R11 size 3 value", {32'h0000_0001, 4'b0001});
    endtask

    task automatic t_flags;
        apply("R9 zero ignores upper", 3'd3, 2'd0, 32'hFFFF_FF01, 1'b0);
        expect_fixed("R9 zero ignores upper value", {32'hFFFF_FF00, 4'b0101});
        apply("R9 n from word msb", 3'd1, 2'd1, 32'h0000_4000, 1'b0);
        apply("R10 asl sign change", 3'd0, 2'd1, 32'h0000_4000, 1'b0);
        expect_fixed("R10 asl v set", {32'h0000_8000, 4'b1010});
        apply("R10 asl no change", 3'd0, 2'd1, 32'h0000_C000, 1'b0);
        expect_fixed("R10 asl v clear", {32'h0000_8000, 4'b1001});
        apply("R10 lsl never v", 3'd1, 2'd0, 32'h0000_0040, 1'b0);
        expect_fixed("R10 lsl v clear", {32'h0000_0080, 4'b1000});
    endtask

    task automatic t_sweep;
        logic [31:0] pat;
        pat = 32'h9E37_79B9;
        for (int op = 0; op < 8; op++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int k = 0; k < 4; k++) begin
                    pat = {pat[30:0], pat[31] ^ pat[21] ^ pat[1] ^ pat[0]} ^ 32'h0101_0101;
                    apply("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 sweep",
                          3'(op), 2'(sz), pat, pat[k]);
                end
            end
        end
    endtask

    initial begin
        t_reset();
        t_latency();
        t_left();
        t_right();
        t_rotate();
        t_carry_rotate();
        t_sizes();
        t_flags();
        t_sweep();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule